// File: doc/BRIEF.md
# Hot-plug repeater power controller

This block is the control part of a link redriver. It samples a hot-plug sense line coming from the sink connector, a power-enable select and a cable-detect line. From these it decides when the redriver is powered and when its outputs are driven. It repeats the hot-plug line toward the source with a fixed delay in clock cycles, and it repeats the cable-detect line with an optional inversion. All timing values are parameters counted in cycles of `clk`.

While the power-enable select is low, the block stays asleep. The main link and the repeated hot-plug output are then disabled, and the hot-plug sense line has no effect. When power-enable is high and the sense line is high, the block wakes up. In the awake state, a short low pulse on the sense line is an interrupt from the sink. It is forwarded at its own width, or stretched up to a minimum width so that it is never lost. A low period that lasts the unplug timeout or longer is taken as an unplug, and the block goes back to sleep.

Every input passes through a two-flop synchroniser before it is used. The synchronous active-high reset puts the block to sleep.

Top module: `hpd_repeater_ctl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `link_en_o`, `hp_oe_o` and `hp_o` are 0.
- R2: While `pwr_en_i` is low, `link_en_o` and `hp_oe_o` stay 0 whatever `hp_sense_i` does. If `pwr_en_i` is sampled low while the block is awake, both fall after the third rising edge, counting the first edge that samples it low.
- R3: When `pwr_en_i` and `hp_sense_i` are both sampled high while the block is asleep, `link_en_o` and `hp_oe_o` rise after the third rising edge. `hp_o` rises after edge HPD_DELAY_CYC+1, counting the first edge at which both are high.
- R4: While the block is awake, a change of `hp_sense_i` appears on `hp_o` after rising edge HPD_DELAY_CYC, counting the first edge that samples the new level.
- R5: While the block is awake, a low pulse sampled low by W edges, with MIN_PULSE <= W < UNPLUG_CYC, appears on `hp_o` as a low pulse exactly W cycles long.
- R6: While the block is awake, a low pulse shorter than MIN_PULSE cycles appears on `hp_o` as a low pulse exactly MIN_PULSE cycles long. A new falling edge during stretching restarts the minimum window.
- R7: While the block is awake, if `hp_sense_i` is sampled low by UNPLUG_CYC consecutive edges, the block goes to sleep. `link_en_o` and `hp_oe_o` fall after edge UNPLUG_CYC+2, counting the first low sample. A low run of UNPLUG_CYC-1 edges leaves the block awake.
- R8: After an unplug, the block wakes again under the rule of R3 once `hp_sense_i` returns high with `pwr_en_i` high.
- R9: `cable_det_o` equals `cable_det_i` XOR `cable_inv_i` as sampled two rising edges earlier, in both power states.
- R10: `hp_o` is 0 whenever `hp_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hp_sense_i | input | 1 | Hot-plug sense from the sink connector (asynchronous) |
| pwr_en_i | input | 1 | Power-enable select, high allows the awake state (asynchronous) |
| cable_det_i | input | 1 | Cable-detect from the connector (asynchronous) |
| cable_inv_i | input | 1 | Invert select for the cable-detect output (asynchronous) |
| hp_o | output | 1 | Repeated hot-plug level toward the source |
| hp_oe_o | output | 1 | Drive enable for `hp_o`; low means high impedance |
| cable_det_o | output | 1 | Repeated cable-detect level |
| link_en_o | output | 1 | Main-link enable |

## Verification
If the power state is wrong, `link_en_o` and `hp_oe_o` are wrong at once, at the latest three edges after the inputs that should have moved it. A lost or stuck stretch count shows up as a pulse on `hp_o` of the wrong width. A bad unplug counter shows as a sleep that comes one cycle early or late around a run of UNPLUG_CYC low samples, so the bench aims pulses of UNPLUG_CYC-1 and UNPLUG_CYC samples at that edge. A pipeline error shows as a first low on `hp_o` at a cycle other than HPD_DELAY_CYC.

// File: rtl/hpd_repeater_ctl.sv
`timescale 1ns/1ps
module hpd_repeater_ctl #(
  parameter int HPD_DELAY_CYC = 18,
  parameter int MIN_PULSE     = 20,
  parameter int UNPLUG_CYC    = 60_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic hp_sense_i,
  input  logic pwr_en_i,
  input  logic cable_det_i,
  input  logic cable_inv_i,
  output logic hp_o,
  output logic hp_oe_o,
  output logic cable_det_o,
  output logic link_en_o
);
  localparam int DL = HPD_DELAY_CYC - 2;
  localparam int CW = $clog2(UNPLUG_CYC + 1);
  localparam int SW = $clog2(MIN_PULSE + 1);

  typedef enum logic {ST_SLEEP, ST_LIVE} st_t;

  logic [1:0] hp_sy, pw_sy, cd_sy, ci_sy;
  logic hp_s, pw_s;
  st_t st;
  logic [CW-1:0] low_cnt;
  logic [DL-1:0] dl;
  logic d_prev;
  logic [SW-1:0] str_cnt;
  logic live, d_hp, unplug;

  always_ff @(posedge clk) begin
    if (rst) begin
      hp_sy <= '0;
      pw_sy <= '0;
      cd_sy <= '0;
      ci_sy <= '0;
    end else begin
      hp_sy <= {hp_sy[0], hp_sense_i};
      pw_sy <= {pw_sy[0], pwr_en_i};
      cd_sy <= {cd_sy[0], cable_det_i};
      ci_sy <= {ci_sy[0], cable_inv_i};
    end
  end

  assign hp_s   = hp_sy[1];
  assign pw_s   = pw_sy[1];
  assign live   = (st == ST_LIVE);
  assign d_hp   = dl[DL-1];
  assign unplug = live && !hp_s && (low_cnt == CW'(UNPLUG_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_SLEEP;
    end else if (!live) begin
      st <= (pw_s && hp_s) ? ST_LIVE : ST_SLEEP;
    end else begin
      st <= (pw_s && !unplug) ? ST_LIVE : ST_SLEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !live || hp_s) begin
      low_cnt <= '0;
    end else if (low_cnt != CW'(UNPLUG_CYC)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !live) begin
      dl      <= '0;
      d_prev  <= 1'b0;
      str_cnt <= '0;
    end else begin
      dl     <= (dl << 1) | DL'(hp_s);
      d_prev <= d_hp;
      if (d_prev && !d_hp)
        str_cnt <= SW'(MIN_PULSE - 1);
      else if (str_cnt != '0)
        str_cnt <= str_cnt - 1'b1;
    end
  end

  assign link_en_o   = live;
  assign hp_oe_o     = live;
  assign hp_o        = live && d_hp && (str_cnt == '0);
  assign cable_det_o = cd_sy[1] ^ ci_sy[1];
endmodule

// File: rtl/hpd_repeater_chk.sv
`timescale 1ns/1ps
module hpd_repeater_chk #(
  parameter int UNPLUG_CYC = 200,
  parameter int MIN_PULSE  = 8,
  parameter int CW         = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          hp_s,
  input logic          pw_s,
  input logic [CW-1:0] low_cnt,
  input logic          hp_o,
  input logic          hp_oe_o,
  input logic          link_en_o,
  input logic          cable_det_o,
  input logic          cable_det_i,
  input logic          cable_inv_i
);
  p_lp_force_r2: assert property (@(posedge clk) disable iff (rst)
    !pw_s |=> !link_en_o);

  p_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (!link_en_o && pw_s && hp_s) |=> link_en_o);

  p_unplug_r7: assert property (@(posedge clk) disable iff (rst)
    (link_en_o && !hp_s && low_cnt == CW'(UNPLUG_CYC - 1)) |=> !link_en_o);

  p_idle_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    !link_en_o |=> (low_cnt == '0));

  p_stretch_r6: assert property (@(posedge clk) disable iff (rst)
    (MIN_PULSE > 1 && hp_oe_o && $past(hp_oe_o) && $fell(hp_o)) |=> (!hp_o || !hp_oe_o));

  p_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !hp_oe_o |-> !hp_o);

  p_cable_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!rst, 2)) |->
      (cable_det_o == ($past(cable_det_i, 2) ^ $past(cable_inv_i, 2))));
endmodule

bind hpd_repeater_ctl hpd_repeater_chk #(
  .UNPLUG_CYC(UNPLUG_CYC), .MIN_PULSE(MIN_PULSE), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .hp_s(hp_s), .pw_s(pw_s), .low_cnt(low_cnt),
  .hp_o(hp_o), .hp_oe_o(hp_oe_o), .link_en_o(link_en_o),
  .cable_det_o(cable_det_o), .cable_det_i(cable_det_i), .cable_inv_i(cable_inv_i)
);

// File: tb/sim_hpd_repeater_ctl.sv
`timescale 1ns/1ps
module sim_hpd_repeater_ctl;
  localparam int DLY  = 6;
  localparam int MINP = 8;
  localparam int UNP  = 200;
  localparam int DL   = DLY - 2;

  logic clk = 1'b0, rst = 1'b1;
  logic hp = 1'b0, pw = 1'b0, cd = 1'b0, ci = 1'b0;
  logic hp_o, hp_oe, cab, link_en;
  int nchk = 0, nfail = 0;
  string st_tag = "R1", hp_tag = "R1";

  hpd_repeater_ctl #(.HPD_DELAY_CYC(DLY), .MIN_PULSE(MINP), .UNPLUG_CYC(UNP)) u0 (
    .clk(clk), .rst(rst), .hp_sense_i(hp), .pwr_en_i(pw), .cable_det_i(cd),
    .cable_inv_i(ci), .hp_o(hp_o), .hp_oe_o(hp_oe), .cable_det_o(cab),
    .link_en_o(link_en));

  always #2.5 clk = ~clk;

  // reference model built from the requirements
  logic [3:0] m1, m2;
  logic ma, mprev;
  int mcnt, mstr;
  logic [DL-1:0] mdl;
  always @(posedge clk) begin
    if (rst) begin
      m1 <= '0; m2 <= '0; ma <= 1'b0; mcnt <= 0; mdl <= '0; mprev <= 1'b0; mstr <= 0;
    end else begin
      m1 <= {hp, pw, cd, ci};
      m2 <= m1;
      if (!ma) begin
        ma <= m2[2] && m2[3];
        mcnt <= 0; mdl <= '0; mprev <= 1'b0; mstr <= 0;
      end else begin
        ma <= m2[2] && !(!m2[3] && mcnt == UNP - 1);
        mcnt <= m2[3] ? 0 : (mcnt < UNP ? mcnt + 1 : mcnt);
        mdl <= {mdl[DL-2:0], m2[3]};
        mprev <= mdl[DL-1];
        if (mprev && !mdl[DL-1]) mstr <= MINP - 1;
        else if (mstr > 0) mstr <= mstr - 1;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string nm);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual %b expected %b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp, input string nm);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(st_tag, link_en, ma, "link_en");
    chk(st_tag, hp_oe, ma, "hp_oe");
    chk(hp_tag, hp_o, ma && mdl[DL-1] && mstr == 0, "hp_o");
    chk("R9", cab, m2[1] ^ m2[0], "cable_det_o");
  endtask

  // low pulse of w sampled edges; checks latency and output width
  task automatic pulse(input int w, input string tag);
    int first = 0, lows = 0;
    int expw = (w < MINP) ? MINP : w;
    hp = 1'b0;
    for (int i = 1; i <= DLY + expw + 6; i++) begin
      tick();
      if (!hp_o) begin
        lows++;
        if (first == 0) first = i;
      end
      if (i == w) hp = 1'b1;
    end
    chk_int("R4", first, DLY, "hp_o fall latency");
    chk_int(tag, lows, expw, "hp_o low width");
  endtask

  task automatic count_link(input logic lvl, input int lim, output int got);
    got = 0;
    for (int i = 1; i <= lim; i++) begin
      tick();
      if (link_en == lvl && got == 0) got = i;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : stim
    int got;
    repeat (4) tick();
    chk("R1", link_en, 1'b0, "link_en in reset");
    chk("R1", hp_oe, 1'b0, "hp_oe in reset");
    rst = 1'b0;
    tick();
    chk("R1", hp_o, 1'b0, "hp_o after reset");

    st_tag = "R2"; hp_tag = "R10";
    for (int k = 0; k < 6; k++) begin
      hp = ~hp;
      repeat (7 + k) tick();
    end
    hp = 1'b1;
    repeat (10) tick();
    chk("R2", link_en, 1'b0, "sleep held with select low");
    chk("R10", hp_o, 1'b0, "hp_o while disabled");

    st_tag = "R3"; hp_tag = "R3";
    pw = 1'b1;
    got = 0;
    for (int i = 1; i <= DLY + 4; i++) begin
      tick();
      if (hp_o && got == 0) got = i;
      if (i == 3) chk("R3", link_en, 1'b1, "wake after third edge");
      if (i == 2) chk("R3", link_en, 1'b0, "not awake before third edge");
    end
    chk_int("R3", got, DLY + 1, "hp_o rise after wake");

    st_tag = "R5"; hp_tag = "R6";
    pulse(1, "R6");
    pulse(3, "R6");
    pulse(MINP - 1, "R6");
    hp_tag = "R5";
    pulse(MINP, "R5");
    pulse(MINP + 5, "R5");
    pulse(40, "R5");
    hp_tag = "R6";
    hp = 1'b0; tick(); tick(); hp = 1'b1; tick(); tick(); hp = 1'b0; tick(); hp = 1'b1;
    repeat (DLY + 2 * MINP) tick();

    st_tag = "R7"; hp_tag = "R7";
    hp = 1'b0;
    repeat (UNP - 1) tick();
    hp = 1'b1;
    repeat (DLY + 4) tick();
    chk("R7", link_en, 1'b1, "awake after UNPLUG_CYC-1 low");
    hp = 1'b0;
    count_link(1'b0, UNP + 10, got);
    chk_int("R7", got, UNP + 2, "unplug edge");
    chk("R10", hp_o, 1'b0, "hp_o after unplug");

    st_tag = "R8"; hp_tag = "R8";
    hp = 1'b1;
    count_link(1'b1, DLY + 4, got);
    chk_int("R8", got, 3, "rewake after unplug");

    st_tag = "R2"; hp_tag = "R10";
    pw = 1'b0;
    count_link(1'b0, 8, got);
    chk_int("R2", got, 3, "forced sleep by select");
    hp = 1'b0; repeat (5) tick(); hp = 1'b1;
    pw = 1'b1;
    st_tag = "R3"; hp_tag = "R3";
    repeat (DLY + 4) tick();

    cd = 1'b1; ci = 1'b0; tick(); tick();
    chk("R9", cab, 1'b1, "cable pass");
    ci = 1'b1; tick(); tick();
    chk("R9", cab, 1'b0, "cable inverted");
    cd = 1'b0; tick(); tick();
    chk("R9", cab, 1'b1, "cable inverted low");

    st_tag = "R8"; hp_tag = "R4";
    void'($urandom(32'd1234));
    for (int s = 0; s < 120; s++) begin
      int len;
      if ($urandom % 12 == 0) pw = ~pw;
      hp = ($urandom % 4) != 0;
      cd = $urandom % 2;
      if ($urandom % 5 == 0) ci = ~ci;
      if (hp) len = 1 + $urandom % 60;
      else if ($urandom % 8 == 0) len = UNP - 2 + $urandom % 5;
      else len = 1 + $urandom % 30;
      repeat (len) tick();
    end
    pw = 1'b1; hp = 1'b1;
    repeat (DLY + 10) tick();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule